// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block holds the control and sequencing logic of one DMA channel. Software programs a peripheral-side address, a memory-side address, an item count and a control word through a small register write port. Once the enable bit is set, every peripheral request is served as one data item. An item is a read beat at the source address followed by a write beat at the destination address, carrying the data just read. Both beats go out on an abstract memory-side port with a valid/ready handshake and an error input.

After each item the channel moves each address that has incrementing enabled by the item size, lowers the remaining count, and raises sticky status flags. The flags mark half the items done, all items done, and a bus error. Each flag has its own interrupt enable, and one interrupt line ORs the enabled flags. A bus error clears the enable bit and stops the channel. In circular operation the count and both addresses reload when the count runs out, so the channel keeps serving requests. The two-bit priority level is only stored and driven out, for an arbiter outside this block.

Top module: `dma_channel`

## Requirements
- R1: After reset the enable bit, all three flags, `irq` and `busValid` are 0.
- R2: Register offsets on `regAddr` are 0 peripheral address, 1 memory address, 2 item count, 3 control and 4 flag clear. Control bits are [0] enable, [1] complete-interrupt enable, [2] half-interrupt enable, [3] error-interrupt enable, [4] direction, [5] circular, [6] peripheral increment, [7] memory increment, [9:8] item size (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes) and [11:10] priority, which is driven on `chanPrio`. While enabled, each request is served as a read beat (`busWrite`=0) at the source, then a write beat (`busWrite`=1) at the destination that carries the read data, and `periphAck` pulses when the write beat completes.
- R3: With direction 0 the source is the peripheral address and the destination is the memory address. With direction 1 they are swapped.
- R4: After each item, an address whose increment bit is set advances by the item size in bytes. An address whose increment bit is clear stays fixed.
- R5: Each item lowers the remaining count by one. Outside circular mode no beat starts once the count reaches 0, the channel stays enabled, and the item that brings the count to 0 sets the complete flag, `flags[0]`.
- R6: The half flag, `flags[1]`, is set by the item after which the remaining count equals the programmed count divided by two and rounded down.
- R7: A beat that completes with `busErr` high sets the error flag, `flags[2]`, clears the enable bit, and starts no further beats.
- R8: `irq` is the OR over the three flags of each flag ANDed with its interrupt enable. Flags stay set until a write of one to the matching bit at offset 4, and a flag set in the same cycle as a clear stays set.
- R9: While enabled, writes to offsets 0 to 2 are ignored, and a control write changes only the enable bit, so writing 0 to the control register disables the channel.
- R10: In circular mode the item that brings the count to 0 reloads the count and both addresses from their programmed values. The channel continues, and the half and complete flags are set again on every pass.
- R11: A count of 0 at enable time produces no beats and sets no flag.
- R12: A beat is held while `busReady` is low, keeping `busValid` high and the address unchanged until the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| regWData | input | REG_W | Register write data |
| periphReq | input | 1 | Peripheral request, level |
| periphAck | output | 1 | Item finished pulse |
| busValid | output | 1 | Beat valid |
| busWrite | output | 1 | 1 for write beat, 0 for read beat |
| busAddr | output | ADDR_W | Beat address |
| busSize | output | 2 | Item size code |
| busWData | output | DATA_W | Write beat data |
| busRData | input | DATA_W | Read beat data |
| busReady | input | 1 | Beat handshake |
| busErr | input | 1 | Error on the beat completing |
| chanEnable | output | 1 | Enable bit |
| chanPrio | output | 2 | Programmed priority level |
| flags | output | 3 | Error, half, complete flags ([2:0]) |
| irq | output | 1 | Channel interrupt |

## Verification
A wrong remaining count shows at the ports within one item. The beat count comes out too high or too low, and the complete or half flag rises at the wrong item. A wrong address register shows on `busAddr` on the very next beat, or on the next pass in circular mode, where a bad reload repeats the wrong start address. If the enable bit is not cleared on an error, a further beat appears within two cycles of the failing one. A configuration field that changes while enabled shows on the addresses or on the item count of the running transfer.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} phase_e;

  typedef struct packed {
    logic rdBeat;
    logic wrBeat;
    logic loadData;
    logic stepItem;
    logic errHit;
  } strobe_t;

  localparam logic [2:0] REG_PADDR = 3'd0;
  localparam logic [2:0] REG_MADDR = 3'd1;
  localparam logic [2:0] REG_COUNT = 3'd2;
  localparam logic [2:0] REG_CTRL  = 3'd3;
  localparam logic [2:0] REG_FCLR  = 3'd4;

  localparam int CTL_EN   = 0;
  localparam int CTL_TCIE = 1;
  localparam int CTL_HTIE = 2;
  localparam int CTL_TEIE = 3;
  localparam int CTL_DIR  = 4;
  localparam int CTL_CIRC = 5;
  localparam int CTL_PINC = 6;
  localparam int CTL_MINC = 7;
  localparam int CTL_SIZE = 8;
  localparam int CTL_PRIO = 10;

  localparam int FLAG_TC = 0;
  localparam int FLAG_HT = 1;
  localparam int FLAG_TE = 2;

endpackage

// File: rtl/dma_ch_ctrl.sv
module dma_ch_ctrl
  import dma_ch_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    active,
  input  logic    periphReq,
  input  logic    busReady,
  input  logic    busErr,
  output strobe_t strb,
  output logic    busValid,
  output logic    busWrite,
  output logic    periphAck
);

  phase_e state, stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (active && periphReq) stateNext = ST_RD;
      ST_RD: begin
        strb.rdBeat = 1'b1;
        if (busReady) begin
          if (busErr) begin
            strb.errHit = 1'b1;
            stateNext   = ST_IDLE;
          end else begin
            strb.loadData = 1'b1;
            stateNext     = ST_WR;
          end
        end
      end
      ST_WR: begin
        strb.wrBeat = 1'b1;
        if (busReady) begin
          if (busErr) strb.errHit   = 1'b1;
          else        strb.stepItem = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busValid  = (state != ST_IDLE);
  assign busWrite  = (state == ST_WR);
  assign periphAck = strb.stepItem;

  // R12: a beat without handshake stays in the same phase
  p_hold_beat_r12: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> busValid && $stable(state));

  // R11: no beat starts while nothing is left to move
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) && !active |=> (state == ST_IDLE));

endmodule

// File: rtl/dma_ch_datapath.sv
module dma_ch_datapath
  import dma_ch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWData,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busRData,
  output logic              active,
  output logic              chanEnable,
  output logic [1:0]        chanPrio,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [DATA_W-1:0] busWData,
  output logic [2:0]        flags,
  output logic              irq
);

  logic [ADDR_W-1:0] perBase, memBase, perCur, memCur, stepAmt;
  logic [CNT_W-1:0]  cntBase, cntCur, cntNext;
  logic [DATA_W-1:0] dataHold;
  logic [2:0]        flagReg, setMask, clrMask;
  logic [1:0]        itemSize, prio;
  logic enBit, ieTc, ieHt, ieTe, dirM2P, circ, pInc, mInc;
  logic cfgWr, enRise, wrapNow;

  assign cfgWr   = regWe && (regAddr == REG_CTRL);
  assign enRise  = cfgWr && regWData[CTL_EN] && !enBit;
  assign cntNext = cntCur - 1'b1;
  assign wrapNow = strb.stepItem && (cntNext == '0);

  always_comb begin
    unique case (itemSize)
      2'd0:    stepAmt = ADDR_W'(1);
      2'd1:    stepAmt = ADDR_W'(2);
      default: stepAmt = ADDR_W'(4);
    endcase
  end

  always_comb begin
    setMask          = '0;
    setMask[FLAG_TC] = wrapNow;
    setMask[FLAG_HT] = strb.stepItem && (cntNext == (cntBase >> 1));
    setMask[FLAG_TE] = strb.errHit;
    clrMask = (regWe && (regAddr == REG_FCLR)) ? regWData[2:0] : 3'b000;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perBase <= '0; memBase <= '0; cntBase <= '0;
      perCur  <= '0; memCur  <= '0; cntCur  <= '0;
      enBit <= 1'b0; ieTc <= 1'b0; ieHt <= 1'b0; ieTe <= 1'b0;
      dirM2P <= 1'b0; circ <= 1'b0; pInc <= 1'b0; mInc <= 1'b0;
      itemSize <= '0; prio <= '0; dataHold <= '0; flagReg <= '0;
    end else begin
      if (regWe && !enBit) begin
        unique case (regAddr)
          REG_PADDR: perBase <= regWData[ADDR_W-1:0];
          REG_MADDR: memBase <= regWData[ADDR_W-1:0];
          REG_COUNT: cntBase <= regWData[CNT_W-1:0];
          REG_CTRL: begin
            ieTc     <= regWData[CTL_TCIE];
            ieHt     <= regWData[CTL_HTIE];
            ieTe     <= regWData[CTL_TEIE];
            dirM2P   <= regWData[CTL_DIR];
            circ     <= regWData[CTL_CIRC];
            pInc     <= regWData[CTL_PINC];
            mInc     <= regWData[CTL_MINC];
            itemSize <= regWData[CTL_SIZE +: 2];
            prio     <= regWData[CTL_PRIO +: 2];
          end
          default: ;
        endcase
      end
      if (strb.errHit)  enBit <= 1'b0;
      else if (cfgWr)   enBit <= regWData[CTL_EN];
      if (enRise) begin
        perCur <= perBase;
        memCur <= memBase;
        cntCur <= cntBase;
      end else if (strb.stepItem) begin
        if (wrapNow && circ) begin
          perCur <= perBase;
          memCur <= memBase;
          cntCur <= cntBase;
        end else begin
          cntCur <= cntNext;
          if (pInc) perCur <= perCur + stepAmt;
          if (mInc) memCur <= memCur + stepAmt;
        end
      end
      if (strb.loadData) dataHold <= busRData;
      flagReg <= (flagReg & ~clrMask) | setMask;
    end
  end

  assign active     = enBit && (cntCur != '0);
  assign chanEnable = enBit;
  assign chanPrio   = prio;
  assign busSize    = itemSize;
  assign busWData   = dataHold;
  assign busAddr    = strb.wrBeat ? (dirM2P ? perCur : memCur)
                                  : (dirM2P ? memCur : perCur);
  assign flags      = flagReg;
  assign irq        = |(flagReg & {ieTe, ieHt, ieTc});

  // R7: an error beat drops the enable and leaves the error flag set
  p_err_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.errHit |=> !enBit && flagReg[FLAG_TE]);

  // R9: programmed values hold still while the channel runs
  p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rstN)
    enBit && $past(enBit) |-> $stable(perBase) && $stable(memBase)
      && $stable(cntBase) && $stable(dirM2P) && $stable(itemSize));

  // R5: the running count never exceeds the programmed count
  p_count_bounded_r5: assert property (@(posedge clk) disable iff (!rstN)
    enBit |-> cntCur <= cntBase);

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_ch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWData,
  input  logic              periphReq,
  output logic              periphAck,
  output logic              busValid,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [1:0]        busSize,
  output logic [DATA_W-1:0] busWData,
  input  logic [DATA_W-1:0] busRData,
  input  logic              busReady,
  input  logic              busErr,
  output logic              chanEnable,
  output logic [1:0]        chanPrio,
  output logic [2:0]        flags,
  output logic              irq
);

  strobe_t strb;
  logic    active;

  dma_ch_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .active    (active),
    .periphReq (periphReq),
    .busReady  (busReady),
    .busErr    (busErr),
    .strb      (strb),
    .busValid  (busValid),
    .busWrite  (busWrite),
    .periphAck (periphAck)
  );

  dma_ch_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .REG_W  (REG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWData   (regWData),
    .strb       (strb),
    .busRData   (busRData),
    .active     (active),
    .chanEnable (chanEnable),
    .chanPrio   (chanPrio),
    .busAddr    (busAddr),
    .busSize    (busSize),
    .busWData   (busWData),
    .flags      (flags),
    .irq        (irq)
  );

endmodule

// File: tb/dma_channel_tb.sv
module dma_channel_tb;

  localparam logic [31:0] K = 32'hA5A5_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWData = '0;
  logic        periphReq = 1'b0;
  logic        periphAck, busValid, busWrite;
  logic [31:0] busAddr, busWData;
  logic [31:0] busRData = '0;
  logic [1:0]  busSize, chanPrio;
  logic        busReady = 1'b0;
  logic        busErr = 1'b0;
  logic        chanEnable, irq;
  logic [2:0]  flags;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int stallCfg = 0;
  int waitCnt = 0;
  logic        errArm = 1'b0;
  logic [31:0] errAddr = '0;

  logic [31:0] logAddr [64];
  logic [31:0] logData [64];
  logic        logWr   [64];
  int          logN = 0;
  int          stallViol = 0;
  int          stallSeen = 0;
  logic        prevPend = 1'b0;
  logic [31:0] prevAddr = '0;

  always #4 clk = ~clk;

  dma_channel u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWData(regWData), .periphReq(periphReq), .periphAck(periphAck),
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busSize(busSize), .busWData(busWData), .busRData(busRData),
    .busReady(busReady), .busErr(busErr), .chanEnable(chanEnable),
    .chanPrio(chanPrio), .flags(flags), .irq(irq)
  );

  // memory-side responder, driven away from the active edge
  always @(negedge clk) begin
    if (busValid) begin
      if (waitCnt >= stallCfg) begin busReady = 1'b1; waitCnt = 0; end
      else begin busReady = 1'b0; waitCnt = waitCnt + 1; end
    end else begin
      busReady = 1'b0; waitCnt = 0;
    end
    busRData = busAddr ^ K;
    busErr   = errArm && busValid && (busAddr == errAddr);
  end

  // beat logger and hold checker
  always @(posedge clk) begin
    if (prevPend && !(busValid && busAddr == prevAddr)) stallViol++;
    if (busValid && !busReady) stallSeen++;
    prevPend = busValid && !busReady;
    prevAddr = busAddr;
    if (busValid && busReady && logN < 64) begin
      logAddr[logN] = busAddr;
      logData[logN] = busWrite ? busWData : busRData;
      logWr[logN]   = busWrite;
      logN++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog: actual cycles=%0d expected<=100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  function automatic logic [31:0] mkCtrl(input logic en, input logic tcIe, input logic htIe,
      input logic teIe, input logic dir, input logic circ, input logic pInc, input logic mInc,
      input logic [1:0] size, input logic [1:0] prio);
    return {20'd0, prio, size, mInc, pInc, circ, dir, teIe, htIe, tcIe, en};
  endfunction

  task automatic clean();
    @(negedge clk);
    periphReq = 1'b0; errArm = 1'b0; stallCfg = 0;
    wr(3'd3, 32'd0);
    wr(3'd4, 32'd7);
    repeat (3) @(negedge clk);
    logN = 0; stallViol = 0; stallSeen = 0;
  endtask

  task automatic runReq(input int n);
    @(negedge clk);
    periphReq = 1'b1;
    repeat (n) @(negedge clk);
    periphReq = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic doItem();
    @(negedge clk);
    periphReq = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (periphAck) break;
    end
    periphReq = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(chanEnable == 1'b0, "R1 enable", 32'(chanEnable), 0);
    chk(flags == 3'b000, "R1 flags", 32'(flags), 0);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);
    chk(busValid == 1'b0, "R1 busValid", 32'(busValid), 0);
  endtask

  task automatic t_basic();
    clean();
    wr(3'd0, 32'h100); wr(3'd1, 32'h2000); wr(3'd2, 32'd3);
    wr(3'd3, mkCtrl(1, 1, 1, 1, 0, 0, 0, 1, 2'd2, 2'd2));
    chk(chanPrio == 2'd2, "R2 priority out", 32'(chanPrio), 2);
    chk(busSize == 2'd2, "R2 size out", 32'(busSize), 2);
    runReq(40);
    chk(logN == 6, "R5 beat count", 32'(logN), 6);
    for (int i = 0; i < 3; i++) begin
      chk(!logWr[2*i] && logAddr[2*i] == 32'h100, "R4 fixed periph read", logAddr[2*i], 32'h100);
      chk(logWr[2*i+1] && logAddr[2*i+1] == 32'h2000 + 32'(4*i), "R4 mem step 4",
          logAddr[2*i+1], 32'h2000 + 32'(4*i));
      chk(logData[2*i+1] == (32'h100 ^ K), "R2 write carries read data", logData[2*i+1], 32'h100 ^ K);
    end
    chk(flags == 3'b011, "R6 half and complete set", 32'(flags), 3);
    chk(irq == 1'b1, "R8 irq set", 32'(irq), 1);
    chk(chanEnable == 1'b1, "R5 stays enabled", 32'(chanEnable), 1);
    wr(3'd4, 32'd1);
    chk(flags == 3'b010, "R8 clear complete only", 32'(flags), 2);
    chk(irq == 1'b1, "R8 irq from half", 32'(irq), 1);
    wr(3'd4, 32'd7);
    chk(flags == 3'b000 && irq == 1'b0, "R8 clear all", {28'd0, irq, flags}, 0);
  endtask

  task automatic t_dir();
    clean();
    stallCfg = 2;
    wr(3'd0, 32'h40); wr(3'd1, 32'h3000); wr(3'd2, 32'd2);
    wr(3'd3, mkCtrl(1, 0, 0, 0, 1, 0, 1, 0, 2'd1, 2'd0));
    runReq(40);
    chk(logN == 4, "R3 beat count", 32'(logN), 4);
    chk(!logWr[0] && logAddr[0] == 32'h3000, "R3 read from memory", logAddr[0], 32'h3000);
    chk(logWr[1] && logAddr[1] == 32'h40, "R3 write to periph", logAddr[1], 32'h40);
    chk(logAddr[2] == 32'h3000, "R4 memory fixed", logAddr[2], 32'h3000);
    chk(logAddr[3] == 32'h42, "R4 periph step 2", logAddr[3], 32'h42);
    chk(logData[3] == (32'h3000 ^ K), "R3 data moved", logData[3], 32'h3000 ^ K);
    chk(flags == 3'b011, "R5 flags set", 32'(flags), 3);
    chk(irq == 1'b0, "R8 irq masked", 32'(irq), 0);
    chk(stallSeen > 0, "R12 stall occurred", 32'(stallSeen), 1);
    chk(stallViol == 0, "R12 held beat", 32'(stallViol), 0);
  endtask

  task automatic t_lock();
    clean();
    wr(3'd0, 32'h500); wr(3'd1, 32'h6000); wr(3'd2, 32'd4);
    wr(3'd3, mkCtrl(1, 0, 0, 0, 0, 0, 0, 1, 2'd0, 2'd1));
    wr(3'd0, 32'h900); wr(3'd1, 32'h7000); wr(3'd2, 32'd1);
    wr(3'd3, mkCtrl(1, 1, 1, 1, 1, 1, 1, 0, 2'd2, 2'd3));
    chk(chanPrio == 2'd1, "R9 priority locked", 32'(chanPrio), 1);
    runReq(60);
    chk(logN == 8, "R9 count locked", 32'(logN), 8);
    chk(logAddr[0] == 32'h500, "R9 periph address locked", logAddr[0], 32'h500);
    chk(logAddr[7] == 32'h6003, "R9 memory and size locked", logAddr[7], 32'h6003);
    chk(irq == 1'b0, "R9 enables locked", 32'(irq), 0);
    wr(3'd3, 32'd0);
    chk(chanEnable == 1'b0, "R9 disable write", 32'(chanEnable), 0);
  endtask

  task automatic t_err();
    clean();
    errAddr = 32'h8004; errArm = 1'b1;
    wr(3'd0, 32'h10); wr(3'd1, 32'h8000); wr(3'd2, 32'd4);
    wr(3'd3, mkCtrl(1, 0, 0, 1, 0, 0, 0, 1, 2'd2, 2'd0));
    runReq(60);
    chk(logN == 4, "R7 beats stop after error", 32'(logN), 4);
    chk(logAddr[3] == 32'h8004, "R7 failing beat", logAddr[3], 32'h8004);
    chk(chanEnable == 1'b0, "R7 enable cleared", 32'(chanEnable), 0);
    chk(flags == 3'b100, "R7 error flag", 32'(flags), 4);
    chk(irq == 1'b1, "R7 error irq", 32'(irq), 1);
  endtask

  task automatic t_circ();
    clean();
    wr(3'd0, 32'h20); wr(3'd1, 32'h9000); wr(3'd2, 32'd2);
    wr(3'd3, mkCtrl(1, 1, 1, 0, 0, 1, 0, 1, 2'd0, 2'd0));
    doItem();
    chk(flags == 3'b010, "R6 half after first", 32'(flags), 2);
    doItem();
    chk(flags == 3'b011, "R10 first pass flags", 32'(flags), 3);
    chk(chanEnable == 1'b1, "R10 still enabled", 32'(chanEnable), 1);
    wr(3'd4, 32'd7);
    doItem();
    chk(flags == 3'b010, "R10 half again", 32'(flags), 2);
    doItem();
    chk(flags == 3'b011, "R10 complete again", 32'(flags), 3);
    chk(logN == 8, "R10 beats", 32'(logN), 8);
    chk(logAddr[5] == 32'h9000, "R10 address reload", logAddr[5], 32'h9000);
    chk(logAddr[7] == 32'h9001, "R10 second pass step", logAddr[7], 32'h9001);
  endtask

  task automatic t_zero();
    clean();
    wr(3'd0, 32'h30); wr(3'd1, 32'hA000); wr(3'd2, 32'd0);
    wr(3'd3, mkCtrl(1, 1, 1, 1, 0, 0, 1, 1, 2'd0, 2'd0));
    runReq(30);
    chk(logN == 0, "R11 no beats", 32'(logN), 0);
    chk(flags == 3'b000, "R11 no flags", 32'(flags), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_dir();
    t_lock();
    t_err();
    t_circ();
    t_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule